// File: doc/BRIEF.md
# Thermal Trip Monitor with Deferred Interrupts

This block compares an 8-bit digital temperature sample with a trip level that software can program. When the sample goes above that level, the block asserts a throttle output. The throttle stays on for a fixed minimum number of clock cycles. After that it stays on until the sample has cooled below the trip level minus a hysteresis margin. The current trip state can be read as a live bit, and a sticky log bit records that a trip has happened.

The block raises one interrupt request on entry into the tripped state, on exit from it, or on both, depending on two enable bits. A mask bit gates delivery of that request. While the throttle is on, no interrupt is delivered. Any request raised during that time is kept in a single pending flag and is presented once the throttle drops. An acknowledge input clears the flag. A free-running timestamp counter counts every clock, whatever the throttle state.

Software reaches the three registers through a plain write-strobe and read-data port.

Top module: `thermtrip_mon`

## Requirements
- R1: When the throttle is off and `temp_i` is strictly greater than the trip level, `throttle_o` is high after the next clock edge. A sample equal to the trip level does not trip.
- R2: Once `throttle_o` rises, it stays high for at least `HOLD_CYC` clock cycles. It stays high for exactly `HOLD_CYC` cycles when the sample is already cool.
- R3: Once the minimum hold has elapsed, the throttle releases only when `temp_i + HYST` is strictly less than the trip level. At any higher sample it stays engaged.
- R4: Control register (address 0) bit 0 enables a pending request on entry into the tripped state.
- R5: Control register bit 1 enables a pending request on exit from the tripped state.
- R6: Control register bit 2 is a mask. While it is 1, `irq_o` is low, but a pending request is kept. After reset the control register reads 0x04, the trip level (address 1) reads `THR_RST`, and status (address 2) reads 0.
- R7: `irq_o` is never high while `throttle_o` is high. A request raised during throttling is delivered in the cycle the throttle drops.
- R8: Status bit 0 reads the live throttle state. Status bit 1 is set on every entry into the tripped state.
- R9: Writing status with bit 1 equal to 0 clears the log bit. Writing bit 1 equal to 1 leaves it unchanged.
- R10: Pending requests are held in a single flag, so several transitions collapse into one request. A one-cycle pulse on `irq_ack_i` clears the flag.
- R11: `tsc_o` increases by one on every clock after reset, whether or not the throttle is on.
- R12: The trip level register at address 1 is writable and readable. A write changes the trip comparison from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| temp_i | input | 8 | Digital temperature sample |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address (0 control, 1 trip level, 2 status) |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational on address |
| irq_ack_i | input | 1 | Clears the pending interrupt flag |
| throttle_o | output | 1 | Throttle engaged |
| irq_o | output | 1 | Thermal interrupt request |
| tsc_o | output | TSC_W | Free-running timestamp counter |

## Verification
A table of temperature samples walks the trip level from below to above. Its values sit exactly at the level, one above it, inside the hysteresis band, on the band edge and one below the band edge. This separates an off-by-one in the trip compare from one in the release compare.

Directed sequences use each enable bit alone, both together and neither. In some of them an enable is turned on after the entry event, while the throttle is already on. Since every delivery is deferred to the release, this is how entry-triggered requests are told apart from exit-triggered ones.

Other sequences cover the following:
- A masked request that appears later, when the mask is cleared.
- Two transitions that must collapse into one request.
- Writes of 1 and of 0 to the log bit.

// File: rtl/thermtrip_pkg.sv
`timescale 1ns/1ps
package thermtrip_pkg;

    typedef enum logic [1:0] {
        ADDR_CTRL = 2'd0,
        ADDR_THR  = 2'd1,
        ADDR_STAT = 2'd2,
        ADDR_RSVD = 2'd3
    } reg_addr_e;

    // rise_en lands on bit 0, fall_en on bit 1, mask on bit 2
    typedef struct packed {
        logic mask;
        logic fall_en;
        logic rise_en;
    } ctrl_t;

    typedef struct packed {
        logic fall;
        logic rise;
    } trip_ev_t;

    typedef enum logic [1:0] {
        ST_COOL = 2'd0,
        ST_HOLD = 2'd1,
        ST_HOT  = 2'd2
    } eng_state_e;

    localparam ctrl_t CTRL_RST = '{mask: 1'b1, fall_en: 1'b0, rise_en: 1'b0};

    function automatic logic is_hot(input logic [7:0] t, input logic [7:0] lvl);
        return t > lvl;
    endfunction

    function automatic logic is_cool(input logic [7:0] t, input logic [7:0] lvl,
                                     input logic [7:0] hyst);
        return ({2'b00, t} + {2'b00, hyst}) < {2'b00, lvl};
    endfunction

endpackage

// File: rtl/thermtrip_regs.sv
`timescale 1ns/1ps
module thermtrip_regs
    import thermtrip_pkg::*;
#(
    parameter logic [7:0] THR_RST = 8'd90
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        we,
    input  logic [1:0]  addr,
    input  logic [7:0]  wdata,
    input  logic        trip_set,
    input  logic        engaged,
    output ctrl_t       ctrl_q,
    output logic [7:0]  thr_q,
    output logic        log_q,
    output logic [7:0]  rdata
);

    reg_addr_e sel;
    assign sel = reg_addr_e'(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_RST;
            thr_q  <= THR_RST;
        end else if (we) begin
            if (sel == ADDR_CTRL) ctrl_q <= ctrl_t'(wdata[2:0]);
            if (sel == ADDR_THR)  thr_q  <= wdata;
        end
    end

    // a new trip wins over a software clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst)                                           log_q <= 1'b0;
        else if (trip_set)                                 log_q <= 1'b1;
        else if (we && sel == ADDR_STAT && !wdata[1])      log_q <= 1'b0;
    end

    always_comb begin
        unique case (sel)
            ADDR_CTRL: rdata = {5'b0, ctrl_q};
            ADDR_THR:  rdata = thr_q;
            ADDR_STAT: rdata = {6'b0, log_q, engaged};
            default:   rdata = 8'h00;
        endcase
    end

endmodule

// File: rtl/thermtrip_engage.sv
`timescale 1ns/1ps
module thermtrip_engage
    import thermtrip_pkg::*;
#(
    parameter int unsigned HOLD_CYC = 200000,
    parameter logic [7:0]  HYST     = 8'd4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] temp,
    input  logic [7:0] thr,
    output logic       engaged,
    output trip_ev_t   ev
);

    localparam int unsigned CNT_W = (HOLD_CYC > 2) ? $clog2(HOLD_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_CYC - 1);

    eng_state_e       st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             hot, cool;

    assign hot  = is_hot(temp, thr);
    assign cool = is_cool(temp, thr, HYST);

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        ev    = '0;
        unique case (st_q)
            ST_COOL: if (hot) begin
                st_d    = ST_HOLD;
                cnt_d   = '0;
                ev.rise = 1'b1;
            end
            ST_HOLD: if (cnt_q == LAST) begin
                if (cool) begin
                    st_d    = ST_COOL;
                    ev.fall = 1'b1;
                end else begin
                    st_d = ST_HOT;
                end
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
            ST_HOT: if (cool) begin
                st_d    = ST_COOL;
                ev.fall = 1'b1;
            end
            default: st_d = ST_COOL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_COOL;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    assign engaged = (st_q != ST_COOL);

endmodule

// File: rtl/thermtrip_irq.sv
`timescale 1ns/1ps
module thermtrip_irq
    import thermtrip_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  trip_ev_t ev,
    input  ctrl_t    ctrl,
    input  logic     engaged,
    input  logic     ack,
    output logic     pending_q,
    output logic     irq
);

    logic raise;
    assign raise = (ev.rise && ctrl.rise_en) || (ev.fall && ctrl.fall_en);

    // a new request wins over an acknowledge in the same cycle
    always_ff @(posedge clk) begin
        if (rst)        pending_q <= 1'b0;
        else if (raise) pending_q <= 1'b1;
        else if (ack)   pending_q <= 1'b0;
    end

    assign irq = pending_q && !ctrl.mask && !engaged;

endmodule

// File: rtl/thermtrip_tsc.sv
`timescale 1ns/1ps
module thermtrip_tsc #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    output logic [W-1:0] cnt_q
);

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/thermtrip_mon.sv
`timescale 1ns/1ps
module thermtrip_mon
    import thermtrip_pkg::*;
#(
    parameter int unsigned HOLD_CYC = 200000,
    parameter logic [7:0]  HYST     = 8'd4,
    parameter logic [7:0]  THR_RST  = 8'd90,
    parameter int unsigned TSC_W    = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [7:0]       temp_i,
    input  logic             reg_we_i,
    input  logic [1:0]       reg_addr_i,
    input  logic [7:0]       reg_wdata_i,
    output logic [7:0]       reg_rdata_o,
    input  logic             irq_ack_i,
    output logic             throttle_o,
    output logic             irq_o,
    output logic [TSC_W-1:0] tsc_o
);

    ctrl_t      ctrl_q;
    logic [7:0] thr_q;
    logic       log_q;
    logic       engaged;
    logic       pending_q;
    trip_ev_t   trip_ev;

    thermtrip_regs #(.THR_RST(THR_RST)) regs_i (
        .clk      (clk),
        .rst      (rst),
        .we       (reg_we_i),
        .addr     (reg_addr_i),
        .wdata    (reg_wdata_i),
        .trip_set (trip_ev.rise),
        .engaged  (engaged),
        .ctrl_q   (ctrl_q),
        .thr_q    (thr_q),
        .log_q    (log_q),
        .rdata    (reg_rdata_o)
    );

    thermtrip_engage #(.HOLD_CYC(HOLD_CYC), .HYST(HYST)) eng_i (
        .clk     (clk),
        .rst     (rst),
        .temp    (temp_i),
        .thr     (thr_q),
        .engaged (engaged),
        .ev      (trip_ev)
    );

    thermtrip_irq irq_i (
        .clk       (clk),
        .rst       (rst),
        .ev        (trip_ev),
        .ctrl      (ctrl_q),
        .engaged   (engaged),
        .ack       (irq_ack_i),
        .pending_q (pending_q),
        .irq       (irq_o)
    );

    thermtrip_tsc #(.W(TSC_W)) tsc_i (
        .clk   (clk),
        .rst   (rst),
        .cnt_q (tsc_o)
    );

    assign throttle_o = engaged;

endmodule

// File: rtl/thermtrip_mon_chk.sv
`timescale 1ns/1ps
module thermtrip_mon_chk #(
    parameter int unsigned HOLD_CYC = 200000,
    parameter logic [7:0]  HYST     = 8'd4,
    parameter int unsigned TSC_W    = 32
) (
    input logic             clk,
    input logic             rst,
    input logic [7:0]       temp_i,
    input logic [7:0]       thr_q,
    input logic             throttle_o,
    input logic             irq_o,
    input logic             irq_ack_i,
    input logic             mask,
    input logic             pending,
    input logic             ev_any,
    input logic             log_q,
    input logic [TSC_W-1:0] tsc_o
);

    logic [31:0] run_cnt;
    logic        past_ok;

    always_ff @(posedge clk) begin
        if (rst)             run_cnt <= '0;
        else if (!throttle_o) run_cnt <= '0;
        else if (run_cnt != 32'hFFFF_FFFF) run_cnt <= run_cnt + 1'b1;
    end

    always_ff @(posedge clk) past_ok <= !rst;

    p_engage_r1: assert property (@(posedge clk) disable iff (rst)
        (!throttle_o && temp_i > thr_q) |=> throttle_o);

    p_min_hold_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(throttle_o) |-> run_cnt >= HOLD_CYC);

    p_no_early_release_r3: assert property (@(posedge clk) disable iff (rst)
        (throttle_o && ({2'b00, temp_i} + {2'b00, HYST} >= {2'b00, thr_q})) |=> throttle_o);

    p_mask_r6: assert property (@(posedge clk) disable iff (rst)
        mask |-> !irq_o);

    p_irq_blocked_r7: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> !throttle_o);

    p_log_on_trip_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(throttle_o) |-> log_q);

    p_ack_clears_r10: assert property (@(posedge clk) disable iff (rst)
        (irq_ack_i && !ev_any) |=> !pending);

    p_tsc_inc_r11: assert property (@(posedge clk) disable iff (rst)
        past_ok |-> tsc_o == TSC_W'($past(tsc_o) + 1'b1));

endmodule

bind thermtrip_mon thermtrip_mon_chk #(
    .HOLD_CYC(HOLD_CYC), .HYST(HYST), .TSC_W(TSC_W)
) chk_i (
    .clk        (clk),
    .rst        (rst),
    .temp_i     (temp_i),
    .thr_q      (thr_q),
    .throttle_o (throttle_o),
    .irq_o      (irq_o),
    .irq_ack_i  (irq_ack_i),
    .mask       (ctrl_q.mask),
    .pending    (pending_q),
    .ev_any     (trip_ev.rise | trip_ev.fall),
    .log_q      (log_q),
    .tsc_o      (tsc_o)
);

// File: tb/thermtrip_mon_tb_top.sv
`timescale 1ns/1ps
module thermtrip_mon_tb_top;

    localparam int unsigned HOLD = 8;
    localparam logic [7:0]  HYS  = 8'd4;
    localparam logic [7:0]  TRST = 8'd90;
    localparam int unsigned TW   = 32;
    localparam int unsigned NVEC = 11;

    // {temperature, expected throttle} with trip level 90, hysteresis 4
    localparam logic [8:0] VEC [NVEC] = '{
        {8'd50,  1'b0}, {8'd90,  1'b0}, {8'd91,  1'b1}, {8'd88, 1'b1},
        {8'd86,  1'b1}, {8'd85,  1'b0}, {8'd200, 1'b1}, {8'd87, 1'b1},
        {8'd20,  1'b0}, {8'd255, 1'b1}, {8'd0,   1'b0}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [7:0]    temp = 8'd0;
    logic          we = 1'b0;
    logic [1:0]    addr = 2'd0;
    logic [7:0]    wdata = 8'd0;
    logic [7:0]    rdata;
    logic          ack = 1'b0;
    logic          throttle;
    logic          irq;
    logic [TW-1:0] tsc;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    thermtrip_mon #(.HOLD_CYC(HOLD), .HYST(HYS), .THR_RST(TRST), .TSC_W(TW)) dut_i (
        .clk(clk), .rst(rst), .temp_i(temp), .reg_we_i(we), .reg_addr_i(addr),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_ack_i(ack),
        .throttle_o(throttle), .irq_o(irq), .tsc_o(tsc)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        we = 1'b1; addr = a; wdata = d;
        tick(1);
        we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic trip();
        temp = 8'd100;
        tick(1);
    endtask

    task automatic cool_down();
        temp = 8'd0;
        for (int g = 0; g < 100 && throttle; g++) tick(1);
    endtask

    task automatic do_ack();
        ack = 1'b1;
        tick(1);
        ack = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0]    d;
        logic [TW-1:0] t0;
        int            n;

        tick(3);
        rst = 1'b0;

        // R6: reset state
        rd(2'd0, d); chk("R6 ctrl reset", d, 8'h04);
        rd(2'd1, d); chk("R6 trip level reset", d, TRST);
        rd(2'd2, d); chk("R6 status reset", d, 8'h00);
        chk("R6 throttle reset", throttle, 0);
        chk("R6 irq reset", irq, 0);

        // R1 R3: trip and hysteresis table
        for (int i = 0; i < NVEC; i++) begin
            temp = VEC[i][8:1];
            tick(12);
            chk($sformatf("R1/R3 vector %0d", i), throttle, VEC[i][0]);
        end

        // R2: exact minimum hold with a cool sample
        temp = 8'd91;
        tick(1);
        temp = 8'd0;
        n = 0;
        for (int g = 0; g < 100 && throttle; g++) begin n++; tick(1); end
        chk("R2 minimum hold length", n, HOLD);

        // R4 R7: entry request deferred until release
        wr(2'd0, 8'h01);
        trip();
        chk("R7 irq blocked at entry", irq, 0);
        tick(3);
        chk("R7 irq blocked during hold", irq, 0);
        cool_down();
        chk("R4 R7 entry request delivered at release", irq, 1);
        do_ack();
        chk("R10 ack clears", irq, 0);

        // R5: exit enabled only after entry
        wr(2'd0, 8'h00);
        trip();
        wr(2'd0, 8'h02);
        cool_down();
        chk("R5 exit request", irq, 1);
        do_ack();

        // R4: entry enabled only after entry gives nothing
        wr(2'd0, 8'h00);
        trip();
        wr(2'd0, 8'h01);
        cool_down();
        tick(1);
        chk("R4 no entry request when enabled late", irq, 0);

        // R6: mask keeps pending
        wr(2'd0, 8'h05);
        trip();
        cool_down();
        tick(1);
        chk("R6 masked irq low", irq, 0);
        wr(2'd0, 8'h01);
        chk("R6 pending shows after unmask", irq, 1);
        do_ack();
        chk("R6 R10 ack after unmask", irq, 0);

        // R10: two transitions collapse
        wr(2'd0, 8'h03);
        trip();
        cool_down();
        chk("R10 one request after two events", irq, 1);
        do_ack();
        tick(1);
        chk("R10 no second request", irq, 0);
        wr(2'd0, 8'h04);

        // R8 R9: live and sticky status
        trip();
        rd(2'd2, d); chk("R8 status while tripped", d, 8'h03);
        cool_down();
        rd(2'd2, d); chk("R8 status after release", d, 8'h02);
        wr(2'd2, 8'h02);
        rd(2'd2, d); chk("R9 write 1 ignored", d, 8'h02);
        wr(2'd2, 8'h00);
        rd(2'd2, d); chk("R9 write 0 clears", d, 8'h00);

        // R12: trip level write
        wr(2'd1, 8'd60);
        rd(2'd1, d); chk("R12 trip level readback", d, 8'd60);
        temp = 8'd60;
        tick(2);
        chk("R12 R1 equal does not trip", throttle, 0);
        temp = 8'd61;
        tick(1);
        chk("R12 R1 new level trips", throttle, 1);

        // R11: counter runs while throttled and after
        t0 = tsc;
        tick(5);
        chk("R11 tsc while throttled", tsc - t0, 5);
        cool_down();
        t0 = tsc;
        tick(7);
        chk("R11 tsc while cool", tsc - t0, 7);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule